// File: doc/BRIEF.md
# E1 Frame Alignment Searcher

This block watches a received E1 bit stream, one bit per valid cycle, and recovers the 256-bit frame boundary. While unlocked it scans every bit for the seven-bit alignment word 0011011. When the word appears it starts a trial: it places its position counter on that word and then checks the spare-word bit of the next frame. It then looks for the alignment word again in the frame after that. Frame lock is declared only when all three checks pass. Any failed step abandons the trial, and the scan goes on with the next received bit.

Once locked, the block checks every second frame for the alignment word. It reports each errored word with a one-cycle pulse and drops lock after three errored words in a row. A level output inverts once for every sixteen errored words, so software can estimate the bit error rate from how often that level changes. The block also exports the current timeslot and bit position, and a pulse that marks the start of each frame while locked.

Top module: `e1_frame_align`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `in_sync`, `ts_cnt`, `bit_cnt`, `frame_start`, `fas_err` and `err_flag` are all 0.
- R2: Each cycle with `rx_vld` high advances the frame position by one, from 255 back to 0. The outputs show it as `ts_cnt` = position/8 and `bit_cnt` = position mod 8, one cycle after the bit. Cycles with `rx_vld` low leave the position unchanged.
- R3: While searching, a bit that completes 0011011 (first bit oldest) over the last seven valid bits is taken as bit 7 of timeslot 0 (position 7). Its frame is then treated as an alignment frame, so its last bit shows `ts_cnt`=31 and `bit_cnt`=7. Bits received before reset never form part of a match.
- R4: After a candidate, the bit at position 1 of the next frame must be 1. If it is 0, the trial is dropped and the scan resumes with the following bit.
- R5: If that bit is 1, the last seven bits at position 7 of the frame after it are compared with 0011011. A match raises `in_sync` one cycle later. A mismatch returns the block to searching.
- R6: While locked, `frame_start` is high for exactly one cycle, the cycle after each valid bit that takes position 0.
- R7: While locked, the seven bits ending at position 7 of every second frame, counted from the alignment frames, are checked. A mismatch gives a one-cycle `fas_err` pulse in the following cycle. Unlocked cycles never pulse `fas_err`.
- R8: The third errored alignment word in a row drops `in_sync` in the same cycle as its `fas_err` pulse, and the search restarts with the next bit.
- R9: `err_flag` inverts on every sixteenth errored alignment word, in the same cycle as that word's `fas_err` pulse. Losing lock does not reset the count of sixteen.
- R10: A correct alignment word clears the run of consecutive errors, so two errored words, then a good one, then two more errored words keep lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Qualifies `rx_bit` in this cycle |
| rx_bit | input | 1 | Received line bit, timeslot MSB first |
| in_sync | output | 1 | Frame lock held |
| ts_cnt | output | 5 | Timeslot of the last valid bit |
| bit_cnt | output | 3 | Bit within the timeslot of the last valid bit |
| frame_start | output | 1 | One-cycle pulse at position 0 while locked |
| fas_err | output | 1 | One-cycle pulse per errored alignment word while locked |
| err_flag | output | 1 | Inverts on every sixteenth errored alignment word |

## Verification
Two events can land in one cycle: the loss of lock on a third consecutive errored word, and the `err_flag` inversion on a sixteenth errored word. The bench provokes this by corrupting alignment words in a fixed schedule. Six pairs of errors, each pair followed by a good word, are followed by a single error and a good word, and then a run of three errors, so that error sixteen is also the third in a row. At that edge, `in_sync` must fall and `err_flag` must invert together with the `fas_err` pulse. The bench judges this against a cycle-by-cycle behavioural model and against a monitor that records whether the two changes fell in the same cycle.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_NFAS = 2'd1,
    ST_FAS2 = 2'd2,
    ST_SYNC = 2'd3
  } fa_state_t;
endpackage

// File: rtl/e1fa_pos_ctr.sv
module e1fa_pos_ctr #(
  parameter int FRAME_BITS = 256,
  parameter int LOAD_POS   = 7,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load,
  output logic [POS_W-1:0] pos_q,
  output logic             frm_q,
  output logic [POS_W-1:0] pos_nx,
  output logic             frm_nx
);
  logic last_bit;

  assign last_bit = (pos_q == POS_W'(FRAME_BITS - 1));

  always_comb begin
    if (load) begin
      pos_nx = POS_W'(LOAD_POS);
      frm_nx = 1'b1;
    end else begin
      pos_nx = last_bit ? '0 : pos_q + POS_W'(1);
      frm_nx = last_bit ? ~frm_q : frm_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      frm_q <= 1'b0;
    end else if (adv) begin
      pos_q <= pos_nx;
      frm_q <= frm_nx;
    end
  end

  // R2: idle cycles hold the position
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pos_q));
endmodule

// File: rtl/e1fa_fas_det.sv
module e1fa_fas_det #(
  parameter int              FAS_LEN  = 7,
  parameter logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  output logic win_eq
);
  logic [FAS_LEN-2:0] hist_q;
  logic [FAS_LEN-1:0] window;

  assign window = {hist_q, din};
  assign win_eq = (window == FAS_WORD);

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '1;
    else if (adv) hist_q <= window[FAS_LEN-2:0];
  end
endmodule

// File: rtl/e1fa_err_mon.sv
module e1fa_err_mon #(
  parameter int LOSS_N  = 3,
  parameter int GROUP_N = 16,
  localparam int CON_W  = $clog2(LOSS_N + 1),
  localparam int GRP_W  = $clog2(GROUP_N)
) (
  input  logic clk,
  input  logic rst,
  input  logic chk,
  input  logic ok,
  output logic lose,
  output logic fas_err_q,
  output logic err_flag_q
);
  logic [CON_W-1:0] con_q;
  logic [GRP_W-1:0] grp_q;
  logic             bad;

  assign bad  = chk && !ok;
  assign lose = bad && (con_q == CON_W'(LOSS_N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      con_q      <= '0;
      grp_q      <= '0;
      fas_err_q  <= 1'b0;
      err_flag_q <= 1'b0;
    end else begin
      fas_err_q <= bad;
      if (chk) begin
        if (ok || lose) con_q <= '0;
        else            con_q <= con_q + CON_W'(1);
      end
      if (bad) begin
        if (grp_q == GRP_W'(GROUP_N - 1)) begin
          grp_q      <= '0;
          err_flag_q <= ~err_flag_q;
        end else begin
          grp_q <= grp_q + GRP_W'(1);
        end
      end
    end
  end

  // R9: the flag only moves together with an error pulse
  a_r9_flag_with_err: assert property (@(posedge clk) disable iff (rst)
    !$stable(err_flag_q) |-> fas_err_q);
  // R10: a good word leaves no error pulse in the next cycle
  a_r10_good_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (chk && ok) |=> !fas_err_q);
endmodule

// File: rtl/e1_frame_align.sv
module e1_frame_align #(
  parameter int                 TS_COUNT = 32,
  parameter int                 TS_BITS  = 8,
  parameter int                 FAS_LEN  = 7,
  parameter logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011,
  parameter int                 NFAS_POS = 1,
  parameter int                 LOSS_N   = 3,
  parameter int                 GROUP_N  = 16,
  localparam int                FRAME_BITS = TS_COUNT * TS_BITS,
  localparam int                POS_W    = $clog2(FRAME_BITS),
  localparam int                TS_W     = $clog2(TS_COUNT),
  localparam int                BIT_W    = $clog2(TS_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_vld,
  input  logic             rx_bit,
  output logic             in_sync,
  output logic [TS_W-1:0]  ts_cnt,
  output logic [BIT_W-1:0] bit_cnt,
  output logic             frame_start,
  output logic             fas_err,
  output logic             err_flag
);
  import e1fa_pkg::*;

  localparam int FAS_POS = TS_BITS - 1;

  fa_state_t        state_q, state_nx;
  logic [POS_W-1:0] pos_q, pos_nx;
  logic             frm_q, frm_nx;
  logic             win_eq, load, at_fas, chk, lose;

  assign load   = rx_vld && (state_q == ST_HUNT) && win_eq;
  assign at_fas = (pos_nx == POS_W'(FAS_POS)) && frm_nx;
  assign chk    = rx_vld && (state_q == ST_SYNC) && at_fas;

  e1fa_pos_ctr #(.FRAME_BITS(FRAME_BITS), .LOAD_POS(FAS_POS)) u_pos (
    .clk(clk), .rst(rst), .adv(rx_vld), .load(load),
    .pos_q(pos_q), .frm_q(frm_q), .pos_nx(pos_nx), .frm_nx(frm_nx)
  );

  e1fa_fas_det #(.FAS_LEN(FAS_LEN), .FAS_WORD(FAS_WORD)) u_det (
    .clk(clk), .rst(rst), .adv(rx_vld), .din(rx_bit), .win_eq(win_eq)
  );

  e1fa_err_mon #(.LOSS_N(LOSS_N), .GROUP_N(GROUP_N)) u_err (
    .clk(clk), .rst(rst), .chk(chk), .ok(win_eq), .lose(lose),
    .fas_err_q(fas_err), .err_flag_q(err_flag)
  );

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_HUNT: if (load) state_nx = ST_NFAS;
      ST_NFAS: if (rx_vld && pos_nx == POS_W'(NFAS_POS))
                 state_nx = rx_bit ? ST_FAS2 : ST_HUNT;
      ST_FAS2: if (rx_vld && at_fas)
                 state_nx = win_eq ? ST_SYNC : ST_HUNT;
      ST_SYNC: if (lose) state_nx = ST_HUNT;
      default: state_nx = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_HUNT;
      in_sync     <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      state_q     <= state_nx;
      in_sync     <= (state_nx == ST_SYNC);
      frame_start <= rx_vld && (pos_nx == '0) && (state_nx == ST_SYNC);
    end
  end

  assign ts_cnt  = pos_q[POS_W-1:BIT_W];
  assign bit_cnt = pos_q[BIT_W-1:0];

  // R8: lock only drops with an error pulse
  a_r8_drop_with_err: assert property (@(posedge clk) disable iff (rst)
    $fell(in_sync) |-> fas_err);
  // R6: frame pulse only at position zero while locked
  a_r6_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (in_sync && ts_cnt == '0 && bit_cnt == '0));
  // R7: error pulses only follow a locked cycle
  a_r7_err_when_locked: assert property (@(posedge clk) disable iff (rst)
    fas_err |-> $past(in_sync));
  // R5: lock is entered only from the confirming check
  a_r5_lock_from_check: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> $past(state_q == ST_FAS2));
endmodule

// File: tb/e1_frame_align_tb.sv
module e1_frame_align_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_vld = 1'b0;
  logic rx_bit = 1'b0;
  logic in_sync, frame_start, fas_err, err_flag;
  logic [4:0] ts_cnt;
  logic [2:0] bit_cnt;

  always #2.5 clk = ~clk;

  e1_frame_align u_dut (
    .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_bit(rx_bit),
    .in_sync(in_sync), .ts_cnt(ts_cnt), .bit_cnt(bit_cnt),
    .frame_start(frame_start), .fas_err(fas_err), .err_flag(err_flag)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit gaps = 1'b1;

  // behavioural reference model
  int m_pos, m_frm, m_st, m_con, m_grp;
  bit m_flag, m_sync, m_start, m_err;
  int hist[6];

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_frm = 0; m_st = 0; m_con = 0; m_grp = 0;
      m_flag = 0; m_sync = 0; m_start = 0; m_err = 0;
      foreach (hist[i]) hist[i] = 1;
    end else begin
      m_start = 0;
      m_err = 0;
      if (rx_vld) begin
        int w, npos, nfrm;
        bit eq;
        w = 0;
        foreach (hist[i]) w = w * 2 + hist[i];
        w = w * 2 + int'(rx_bit);
        eq = (w == 27);
        if (m_st == 0 && eq) begin
          npos = 7; nfrm = 1;
        end else begin
          npos = (m_pos + 1) % 256;
          nfrm = (m_pos == 255) ? 1 - m_frm : m_frm;
        end
        if (m_st == 0) begin
          if (eq) m_st = 1;
        end else if (m_st == 1) begin
          if (npos == 1) m_st = rx_bit ? 2 : 0;
        end else if (m_st == 2) begin
          if (npos == 7 && nfrm == 1) m_st = eq ? 3 : 0;
        end else if (npos == 7 && nfrm == 1) begin
          if (eq) m_con = 0;
          else begin
            m_err = 1;
            m_grp++;
            if (m_grp == 16) begin m_grp = 0; m_flag = !m_flag; end
            m_con++;
            if (m_con == 3) begin m_con = 0; m_st = 0; end
          end
        end
        m_pos = npos; m_frm = nfrm;
        m_sync = (m_st == 3);
        m_start = (npos == 0) && (m_st == 3);
        for (int i = 0; i < 5; i++) hist[i] = hist[i+1];
        hist[5] = int'(rx_bit);
      end
    end
  end

  // event monitors
  int err_pulses = 0, toggles = 0, falls = 0;
  bit coincide = 0, p_sync = 0, p_flag = 0;

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(in_sync === m_sync, "R5", "in_sync", in_sync, m_sync);
      check(ts_cnt === 5'(m_pos / 8), "R2", "ts_cnt", ts_cnt, m_pos / 8);
      check(bit_cnt === 3'(m_pos % 8), "R2", "bit_cnt", bit_cnt, m_pos % 8);
      check(frame_start === m_start, "R6", "frame_start", frame_start, m_start);
      check(fas_err === m_err, "R7", "fas_err", fas_err, m_err);
      check(err_flag === m_flag, "R9", "err_flag", err_flag, m_flag);
      if (fas_err) err_pulses++;
      if (err_flag != p_flag) toggles++;
      if (p_sync && !in_sync) begin
        falls++;
        if (err_flag != p_flag && fas_err) coincide = 1;
      end
      p_sync = in_sync;
      p_flag = err_flag;
    end
  end

  task automatic send_bit(input bit b);
    if (gaps && ($urandom % 5 == 0)) begin
      @(negedge clk); rx_vld = 1'b0;
    end
    @(negedge clk); rx_vld = 1'b1; rx_bit = b;
  endtask

  task automatic send_frame(input bit is_fas, input bit good, input bit b2,
                            input bit rnd);
    for (int ts = 0; ts < 32; ts++) begin
      logic [7:0] oct;
      if (ts == 0)
        oct = is_fas ? {1'b1, (good ? 7'b0011011 : 7'b0011010)}
                     : {1'b1, b2, 6'b111111};
      else
        oct = rnd ? 8'($urandom) : 8'h00;
      for (int b = 7; b >= 0; b--) send_bit(oct[b]);
    end
  endtask

  task automatic pause;
    @(negedge clk); rx_vld = 1'b0;
    #0.5;
  endtask

  localparam logic [22:0] SCHED = 23'b110_110_110_110_110_110_10_111;

  initial begin
    repeat (4) @(negedge clk);
    check(in_sync === 0 && ts_cnt === 0 && bit_cnt === 0 && frame_start === 0
          && fas_err === 0 && err_flag === 0, "R1", "outputs in reset", 0, 0);
    rst = 1'b0;
    @(negedge clk); #0.5;
    check(in_sync === 0 && ts_cnt === 0 && bit_cnt === 0 && err_flag === 0,
          "R1", "outputs after reset", {in_sync, ts_cnt, bit_cnt}, 0);

    for (int i = 0; i < 13; i++) send_bit(1'b0);
    send_frame(1, 1, 1, 0);
    pause;
    check(ts_cnt === 5'd31 && bit_cnt === 3'd7, "R3", "position at end of candidate frame",
          {ts_cnt, bit_cnt}, {5'd31, 3'd7});
    check(in_sync === 0, "R3", "no lock on candidate", in_sync, 0);
    send_frame(0, 1, 0, 0);
    send_frame(1, 1, 1, 0);
    pause;
    check(in_sync === 0, "R4", "bad spare bit rejects trial", in_sync, 0);
    send_frame(0, 1, 1, 0);
    pause;
    check(in_sync === 0, "R5", "no lock before confirming word", in_sync, 0);
    send_frame(1, 1, 1, 0);
    pause;
    check(in_sync === 1, "R5", "lock after confirming word", in_sync, 1);

    for (int i = 0; i < 2; i++) begin
      send_frame(0, 1, 1, 1);
      send_frame(1, 1, 1, 1);
    end
    pause;
    check(err_pulses == 0, "R7", "no errors on good words", err_pulses, 0);

    for (int i = 22; i >= 0; i--) begin
      send_frame(0, 1, 1, 1);
      send_frame(1, !SCHED[i], 1, 0);
      if (i == 3) begin
        pause;
        check(in_sync === 1, "R10", "pairs of errors keep lock", in_sync, 1);
        check(err_pulses == 13, "R7", "error pulses so far", err_pulses, 13);
      end
    end
    pause;
    check(in_sync === 0, "R8", "third error in a row drops lock", in_sync, 0);
    check(falls == 1, "R8", "lock losses", falls, 1);
    check(err_pulses == 16, "R7", "error pulses", err_pulses, 16);
    check(toggles == 1 && err_flag === 1, "R9", "flag inversions", toggles, 1);
    check(coincide == 1, "R8", "loss and flag change in one cycle", coincide, 1);

    send_frame(0, 1, 1, 0);
    send_frame(1, 1, 1, 0);
    send_frame(0, 1, 1, 0);
    send_frame(1, 1, 1, 0);
    pause;
    check(in_sync === 1, "R5", "lock regained", in_sync, 1);
    check(err_flag === 1, "R9", "flag survives loss", err_flag, 1);

    gaps = 1'b0;
    for (int i = 0; i < 3; i++) begin
      send_frame(0, 1, 1, 1);
      send_frame(1, 1, 1, 1);
    end
    pause;
    check(in_sync === 1 && err_pulses == 16, "R7", "random data in locked frames",
          err_pulses, 16);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule